// File: doc/BRIEF.md
# Simultaneous-Sampling ADC Frame Reader

This block sits on the host side of an external multi-channel converter that samples all of its inputs at the same instant and returns the results over a 16-bit parallel bus. When the host asks for a frame, the reader sends one conversion-start pulse that goes to every channel group. It then waits for the converter's busy line to rise and fall again. After that it strobes a combined chip-select/read line once per channel, from channel 1 upwards, and stores each word in a result bank indexed by channel.

The reader always reads the full channel count, because the converter puts every channel in its output stream. The converter's first-data flag is checked on every strobe: it must be high for channel 1 and low for every later channel. A wrong flag gives an alignment error pulse. If busy does not complete its high-then-low sequence within a programmable number of cycles, the frame is abandoned with a timeout pulse. The conversion pulse width, the strobe low and high widths, the capture delay and the timeout bound are run-time inputs. The busy and first-data inputs pass through two-flop synchronizers before any logic uses them.

The controller states are IDLE, CONV (start pulse), WAIT (busy handshake), RD_LO (strobe low, capture), RD_HI (strobe high) and DONE (end-of-frame pulse). The transitions are:
- IDLE→CONV on a start request.
- CONV→WAIT when the pulse width is reached.
- WAIT→RD_LO when busy has been seen high and is now low.
- WAIT→IDLE on timeout.
- RD_LO→RD_HI after the low width when channels remain.
- RD_HI→RD_LO after the high width.
- RD_LO→DONE after the low width of the last channel.
- DONE→IDLE unconditionally.

Top module: `adc_frame_reader`

## Requirements
- R1: While reset is asserted and afterwards until the first start, the conversion start output is 0, the strobe is 1 and done, timeout and alignment outputs are 0. Every bank entry reads 0.
- R2: A start request sampled high in IDLE makes the conversion start output high from the following cycle for exactly cfg_conv_w cycles. A value of 0 acts as 1.
- R3: The first strobe low cycle comes on the third rising clock edge after the edge that first samples busy low, but only after the synchronized busy has been seen high in the same frame.
- R4: Each frame has exactly NCH strobes. Each stays low for cfg_rd_lo cycles, with cfg_rd_hi high cycles between strobes (0 acts as 1). The strobe is never low while the conversion start output is high.
- R5: The bus word is captured in the strobe low cycle whose count (0 = first low cycle) equals cfg_samp, with 2 ≤ cfg_samp < cfg_rd_lo. Strobe k (k=0 first) stores to bank index k, which holds channel k+1, and the entry can be read on rd_data by setting rd_addr.
- R6: The expected first-data flag is 1 at strobe 0 and 0 at every later strobe. The flag is checked at the capture cycle. Each mismatch gives a one-cycle align_err pulse in the cycle after that capture.
- R7: In the cycle after the last strobe's low phase, done is high for exactly one cycle and the strobe is high.
- R8: A timer is 0 in the first conversion pulse cycle and counts every cycle after it. If busy has not completed its high-then-low sequence when the timer reaches cfg_timeout (cfg_timeout ≥ pulse width), timeout_err pulses in the next cycle and the reader returns to IDLE without strobing.
- R9: Start requests that arrive in any state other than IDLE, including the DONE cycle, are ignored.
- R10: A frame that ends by timeout leaves every bank entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Frame request, acted on only in IDLE |
| cfg_conv_w | input | CW | Conversion start pulse width in cycles |
| cfg_rd_lo | input | CW | Strobe low width in cycles |
| cfg_rd_hi | input | CW | Strobe high width between strobes |
| cfg_samp | input | CW | Capture cycle inside the strobe low phase |
| cfg_timeout | input | TW | Busy handshake bound in cycles |
| adc_busy | input | 1 | Converter busy (asynchronous) |
| adc_frst | input | 1 | Converter first-data flag (asynchronous) |
| adc_db | input | DW | Converter parallel data bus |
| rd_addr | input | IDX_W | Result bank read index |
| adc_convst | output | 1 | Shared conversion start for all channel groups |
| adc_cs_rd_n | output | 1 | Combined chip-select/read strobe, active low |
| rd_data | output | DW | Result bank read data |
| done | output | 1 | One-cycle end-of-frame pulse |
| timeout_err | output | 1 | One-cycle busy timeout pulse |
| align_err | output | 1 | One-cycle first-data mismatch pulse |

## Verification
The start pulse begins one cycle after the request. After busy falls, two synchronizer flops and the state register put the first strobe three edges later. Each alignment error appears one cycle after its capture cycle, done appears in the cycle after the final low phase, and a timeout appears one cycle after the timer meets its bound. The bench turns these latencies into a per-cycle expected value for every output, indexed from the edge that accepts the start. It compares the outputs on every falling clock edge, so each check falls in the exact cycle the requirement names. The bench drives the first-data flag as soon as the strobe falls, so its model meets the two-cycle synchronizer lag that the cfg_samp lower bound allows for.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CONV  = 3'd1,
        ST_WAIT  = 3'd2,
        ST_RD_LO = 3'd3,
        ST_RD_HI = 3'd4,
        ST_DONE  = 3'd5
    } rd_state_e;
endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_bit
            logic meta;
            logic stab;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    meta <= 1'b0;
                    stab <= 1'b0;
                end else begin
                    meta <= d[g];
                    stab <= meta;
                end
            end
            assign q[g] = stab;
        end
    endgenerate
endmodule

// File: rtl/adc_rd_bank.sv
module adc_rd_bank #(
    parameter int NCH   = 8,
    parameter int DW    = 16,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [DW-1:0]    wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0] slot [NCH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) slot[i] <= '0;
        end else if (we) begin
            for (int i = 0; i < NCH; i++) begin
                if (widx == IDX_W'(i)) slot[i] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (raddr == IDX_W'(i)) rdata = slot[i];
        end
    end
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import adc_rd_pkg::*;
#(
    parameter int NCH = 8,
    parameter int DW  = 16,
    parameter int CW  = 8,
    parameter int TW  = 16,
    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CW-1:0]    cfg_conv_w,
    input  logic [CW-1:0]    cfg_rd_lo,
    input  logic [CW-1:0]    cfg_rd_hi,
    input  logic [CW-1:0]    cfg_samp,
    input  logic [TW-1:0]    cfg_timeout,
    input  logic             adc_busy,
    input  logic             adc_frst,
    input  logic [DW-1:0]    adc_db,
    input  logic [IDX_W-1:0] rd_addr,
    output logic             adc_convst,
    output logic             adc_cs_rd_n,
    output logic [DW-1:0]    rd_data,
    output logic             done,
    output logic             timeout_err,
    output logic             align_err
);
    localparam logic [IDX_W-1:0] LAST_CH = IDX_W'(NCH - 1);

    rd_state_e        st, st_nx;
    logic [CW-1:0]    cnt;
    logic [TW-1:0]    tmr;
    logic [IDX_W-1:0] ch;
    logic             seen_hi;
    logic             busy_s, frst_s;
    logic [CW-1:0]    w_sel;
    logic [CW:0]      cnt_p1;
    logic             phase_end, tmo, samp_now, last_ch;

    adc_rd_sync #(.WIDTH(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({adc_frst, adc_busy}),
        .q     ({frst_s, busy_s})
    );

    adc_rd_bank #(.NCH(NCH), .DW(DW), .IDX_W(IDX_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (samp_now),
        .widx  (ch),
        .wdata (adc_db),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    // width of the phase the current state is timing
    always_comb begin
        unique case (st)
            ST_CONV:  w_sel = cfg_conv_w;
            ST_RD_LO: w_sel = cfg_rd_lo;
            ST_RD_HI: w_sel = cfg_rd_hi;
            default:  w_sel = CW'(1);
        endcase
    end

    assign cnt_p1    = {1'b0, cnt} + (CW+1)'(1);
    assign phase_end = (cnt_p1 >= {1'b0, w_sel});
    assign tmo       = (tmr >= cfg_timeout);
    assign samp_now  = (st == ST_RD_LO) && (cnt == cfg_samp);
    assign last_ch   = (ch == LAST_CH);

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (start) st_nx = ST_CONV;
            ST_CONV:  if (phase_end) st_nx = ST_WAIT;
            ST_WAIT: begin
                if (tmo)                     st_nx = ST_IDLE;
                else if (seen_hi && !busy_s) st_nx = ST_RD_LO;
            end
            ST_RD_LO: if (phase_end) st_nx = last_ch ? ST_DONE : ST_RD_HI;
            ST_RD_HI: if (phase_end) st_nx = ST_RD_LO;
            ST_DONE:  st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // state register and its counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            tmr     <= '0;
            ch      <= '0;
            seen_hi <= 1'b0;
        end else begin
            st  <= st_nx;
            cnt <= (st_nx != st) ? '0 : cnt + CW'(1);
            tmr <= (st == ST_IDLE) ? '0 : tmr + TW'(1);
            if (st == ST_IDLE)
                ch <= '0;
            else if (st == ST_RD_LO && phase_end && !last_ch)
                ch <= ch + IDX_W'(1);
            if (st == ST_IDLE)
                seen_hi <= 1'b0;
            else if (busy_s)
                seen_hi <= 1'b1;
        end
    end

    // registered outputs, aligned with the state they belong to
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adc_convst  <= 1'b0;
            adc_cs_rd_n <= 1'b1;
            done        <= 1'b0;
            timeout_err <= 1'b0;
            align_err   <= 1'b0;
        end else begin
            adc_convst  <= (st_nx == ST_CONV);
            adc_cs_rd_n <= (st_nx != ST_RD_LO);
            done        <= (st_nx == ST_DONE);
            timeout_err <= (st == ST_WAIT) && tmo;
            align_err   <= samp_now && (frst_s != (ch == '0));
        end
    end
endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic adc_convst,
    input logic adc_cs_rd_n,
    input logic done,
    input logic timeout_err,
    input logic busy_s
);
    // R2 / R9: a conversion pulse only ever follows an accepted request
    a_r2_convst_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_convst) |-> $past(start));

    // R4: strobe and conversion pulse are never active together
    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        adc_convst |-> adc_cs_rd_n);

    // R3: a strobe only starts once synchronized busy is low
    a_r3_strobe_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_rd_n) |-> !busy_s);

    // R7: done is a single-cycle pulse
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: done comes with the strobe released
    a_r7_done_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (adc_cs_rd_n && !adc_convst));

    // R8: a timed-out frame never strobes or completes
    a_r8_tmo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> (adc_cs_rd_n && !done));
endmodule

bind adc_frame_reader adc_frame_reader_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .adc_convst  (adc_convst),
    .adc_cs_rd_n (adc_cs_rd_n),
    .done        (done),
    .timeout_err (timeout_err),
    .busy_s      (busy_s)
);

// File: tb/adc_frame_reader_tb.sv
module adc_frame_reader_tb;
    localparam int NCH = 8;
    localparam int DW  = 16;
    localparam int CW  = 8;
    localparam int TW  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] cfg_conv_w = '0, cfg_rd_lo = '0, cfg_rd_hi = '0, cfg_samp = '0;
    logic [TW-1:0] cfg_timeout = '0;
    logic          adc_busy = 1'b0, adc_frst = 1'b0;
    logic [DW-1:0] adc_db = '0;
    logic [2:0]    rd_addr = '0;
    logic          adc_convst, adc_cs_rd_n, done, timeout_err, align_err;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [DW-1:0] exp_bank [NCH];

    always #4 clk = ~clk;

    adc_frame_reader #(.NCH(NCH), .DW(DW), .CW(CW), .TW(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_conv_w(cfg_conv_w), .cfg_rd_lo(cfg_rd_lo), .cfg_rd_hi(cfg_rd_hi),
        .cfg_samp(cfg_samp), .cfg_timeout(cfg_timeout),
        .adc_busy(adc_busy), .adc_frst(adc_frst), .adc_db(adc_db),
        .rd_addr(rd_addr), .adc_convst(adc_convst), .adc_cs_rd_n(adc_cs_rd_n),
        .rd_data(rd_data), .done(done), .timeout_err(timeout_err), .align_err(align_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_bank(input string req);
        for (int c = 0; c < NCH; c++) begin
            rd_addr = 3'(c);
            #1;
            chk(rd_data === exp_bank[c], req, $sformatf("bank[%0d]", c),
                int'(rd_data), int'(exp_bank[c]));
        end
    endtask

    // one full frame; index n is the cycle after the edge that accepts start
    task automatic run_frame(input int cw, input int lo, input int hi, input int samp,
                             input int b, input logic [7:0] bad, input int seed,
                             input bit poke);
        int cwe = (cw == 0) ? 1 : cw;
        int loe = (lo == 0) ? 1 : lo;
        int hie = (hi == 0) ? 1 : hi;
        int rs = b + 3;
        int period = loe + hie;
        int rdlen = NCH * loe + (NCH - 1) * hie;
        int last = rs + rdlen + 3;
        logic [DW-1:0] word [NCH];
        for (int c = 0; c < NCH; c++) word[c] = DW'(seed + c * 16'h1357);
        cfg_conv_w = CW'(cw); cfg_rd_lo = CW'(lo); cfg_rd_hi = CW'(hi);
        cfg_samp = CW'(samp); cfg_timeout = TW'(1000);
        start = 1'b1;
        tick();
        start = 1'b0;
        for (int n = 0; n <= last; n++) begin
            int rel = n - rs;
            bit cs_e = 1'b1;
            bit al_e = 1'b0;
            bit done_e = (rel == rdlen);
            if (rel >= 0 && rel < rdlen) cs_e = ((rel % period) >= loe);
            for (int c = 0; c < NCH; c++)
                if (bad[c] && n == rs + c * period + samp + 1) al_e = 1'b1;
            chk(adc_convst === (n < cwe), (poke && n >= cwe) ? "R9" : "R2",
                "convst", int'(adc_convst), int'(n < cwe));
            chk(adc_cs_rd_n === cs_e, (n == rs) ? "R3" : "R4",
                "cs_rd_n", int'(adc_cs_rd_n), int'(cs_e));
            chk(done === done_e, "R7", "done", int'(done), int'(done_e));
            chk(align_err === al_e, "R6", "align_err", int'(align_err), int'(al_e));
            chk(timeout_err === 1'b0, "R8", "timeout_err", int'(timeout_err), 0);
            // converter model
            if (n == 0) adc_busy = 1'b1;
            if (n == b) adc_busy = 1'b0;
            if (rel >= 0 && rel < rdlen) begin
                int c = rel / period;
                if (rel % period == 0) begin
                    adc_db = word[c];
                    adc_frst = (c == 0) ^ bad[c];
                end else if (rel % period == loe) begin
                    adc_db = '0;
                    adc_frst = 1'b0;
                end
            end else if (rel == rdlen) begin
                adc_db = '0;
                adc_frst = 1'b0;
            end
            start = poke && (n == 2 || n == rs + 1 || n == rs + rdlen);
            tick();
        end
        start = 1'b0;
        for (int c = 0; c < NCH; c++) exp_bank[c] = word[c];
        check_bank("R5");
    endtask

    // busy never completes: stuck low (stuck=0) or stuck high (stuck=1)
    task automatic run_timeout(input int cw, input int t, input bit stuck);
        int cwe = (cw == 0) ? 1 : cw;
        cfg_conv_w = CW'(cw); cfg_timeout = TW'(t);
        start = 1'b1;
        tick();
        start = 1'b0;
        for (int n = 0; n <= t + 4; n++) begin
            chk(adc_convst === (n < cwe), "R2", "convst", int'(adc_convst), int'(n < cwe));
            chk(adc_cs_rd_n === 1'b1, "R8", "cs_rd_n", int'(adc_cs_rd_n), 1);
            chk(done === 1'b0, "R8", "done", int'(done), 0);
            chk(timeout_err === (n == t + 1), "R8", "timeout_err",
                int'(timeout_err), int'(n == t + 1));
            if (stuck && n == 0) adc_busy = 1'b1;
            tick();
        end
        adc_busy = 1'b0;
        repeat (4) tick();
        check_bank("R10");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) exp_bank[c] = '0;
        repeat (3) tick();
        chk(adc_convst === 1'b0 && adc_cs_rd_n === 1'b1, "R1", "pins in reset",
            int'({adc_convst, adc_cs_rd_n}), 1);
        rst_n = 1'b1;
        repeat (3) tick();
        chk(adc_convst === 1'b0 && adc_cs_rd_n === 1'b1 && done === 1'b0
            && timeout_err === 1'b0 && align_err === 1'b0, "R1", "idle outputs",
            int'({adc_convst, adc_cs_rd_n, done, timeout_err, align_err}), 8);
        check_bank("R1");

        run_frame(3, 4, 2, 2, 10, 8'h00, 16'h0101, 1'b0);
        run_frame(0, 3, 0, 2, 6, 8'b0000_1001, 16'hA5C3, 1'b1);
        repeat (3) tick();
        run_timeout(2, 12, 1'b0);
        run_timeout(4, 20, 1'b1);
        run_frame(1, 6, 3, 5, 20, 8'h80, 16'h7E11, 1'b0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule